// File: doc/BRIEF.md
# Clock-chip interrupt flag and enable unit

This block keeps the interrupt bookkeeping of a real-time clock. Three single-cycle event pulses arrive from the timekeeping logic: a periodic tick, an alarm match and an update-ended notice. Each pulse latches its own flag in a status byte. When a latched flag is also enabled, a summary bit in that byte is set and the active-high interrupt line rises.

The host reaches four byte-wide registers through a small synchronous port. The port has a 2-bit address, a write strobe, a read strobe, a write byte and a combinational read byte. Address 0 is a general control byte. Address 1 is the enable byte. Address 2 is the status byte, which clears when it is read. Address 3 is a fixed status byte. Writing the enable byte decides on the spot whether the line is high or low. This means a flag that is already pending interrupts as soon as its source is unmasked. A hold bit in the enable byte stops the update-ended source from being enabled.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, address 0 reads 0x26, address 1 reads 0x02, address 2 reads 0x00, address 3 reads 0x80, and `irqOut` is low.
- R2: A periodic pulse always sets status bit 6 (0x40). It also sets the summary bit 7 (0x80) and raises `irqOut` one cycle later, but only when enable bit 6 is set.
- R3: An alarm pulse sets status bit 5 (0x20) and an update pulse sets status bit 4 (0x10). The summary bit and `irqOut` are set only when the flag was not already set and the matching enable bit (5 or 4) is set. `irqOut` is never high while status bits 6..4 are all zero.
- R4: A read of address 2 returns the current status byte. The status byte is then 0x00 and `irqOut` is low from the next cycle on, unless an event pulse arrives in the same cycle.
- R5: A write to address 1 sets the summary bit and raises `irqOut` when the stored enable value ANDed with status bits 6..4 is nonzero. Otherwise it clears the summary bit and lowers `irqOut`. The flags themselves are kept in both cases.
- R6: A write to address 1 with bit 7 (hold) set stores bit 4 (update enable) as 0. All other bits are stored as written.
- R7: Writes to address 2 and address 3 are ignored. Address 3 always reads 0x80.
- R8: When an event pulse and a status read fall in the same cycle, the read returns the old byte. The new flag is kept after the clear, and it counts as newly set for the R3 rule.
- R9: Address 0 stores and reads back any written byte. Address 1 reads back its stored value. A cycle with both strobes high is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select (0 control, 1 enable, 2 status, 3 fixed) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; a status read clears the flags |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte, valid in the cycle of `busRd`, 0 otherwise |
| evPeriodic | input | 1 | Periodic tick pulse |
| evAlarm | input | 1 | Alarm match pulse |
| evUpdate | input | 1 | Update-ended pulse |
| irqOut | output | 1 | Interrupt line, active high |

## Verification
Two pairs of functions can collide in the same cycle: a flag-clearing status read with an event pulse, and an enable write with an event pulse. Random stimulus with a fixed seed hits both collisions often, and directed steps force each one on purpose. Every returned byte and every following `irqOut` value is compared against a bench model. In that model the read sees the old byte, the clear happens first and the new flag is then ORed in. For an enable write, the decision uses the new enable value and the event is added on top.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DataW = 8;
  localparam int AddrW = 2;

  localparam logic [AddrW-1:0] RegCtrlA  = 2'd0;
  localparam logic [AddrW-1:0] RegEnable = 2'd1;
  localparam logic [AddrW-1:0] RegStatus = 2'd2;
  localparam logic [AddrW-1:0] RegCtrlD  = 2'd3;

  // status bit positions
  localparam int StSum = 7;
  localparam int StPer = 6;
  localparam int StAlm = 5;
  localparam int StUpd = 4;
  // enable bit positions
  localparam int EnHold = 7;
  localparam int EnSqw  = 3;

  localparam logic [DataW-1:0] FlagMask = 8'h70;
  localparam logic [DataW-1:0] EdgeMask = 8'h30;

  localparam logic [DataW-1:0] RstCtrlA  = 8'h26;
  localparam logic [DataW-1:0] RstEnable = 8'h02;
  localparam logic [DataW-1:0] RstStatus = 8'h00;
  localparam logic [DataW-1:0] RstCtrlD  = 8'h80;

  typedef struct packed {
    logic             wrCtrlA;
    logic             wrEnable;
    logic             rdStatus;
    logic [DataW-1:0] wrValue;
    logic [DataW-1:0] enValue;
  } strobeT;
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [DataW-1:0] busWrData,
  output strobeT           strobe
);
  logic [DataW-1:0] holdMask;

  always_comb begin
    holdMask = '1;
    if (busWrData[EnHold]) holdMask[StUpd] = 1'b0;
    strobe.wrCtrlA  = busWr && (busAddr == RegCtrlA);
    strobe.wrEnable = busWr && (busAddr == RegEnable);
    strobe.rdStatus = busRd && !busWr && (busAddr == RegStatus);
    strobe.wrValue  = busWrData;
    strobe.enValue  = busWrData & holdMask;
  end
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic             evPeriodic,
  input  logic             evAlarm,
  input  logic             evUpdate,
  output logic [DataW-1:0] ctrlAQ,
  output logic [DataW-1:0] enableQ,
  output logic [DataW-1:0] statusQ
);
  logic [DataW-1:0] baseStat;
  logic [DataW-1:0] enNext;
  logic [DataW-1:0] evBits;
  logic [DataW-1:0] freshBits;
  logic [DataW-1:0] statNext;
  logic             sumNext;

  always_comb begin
    baseStat = strobe.rdStatus ? '0 : statusQ;
    enNext   = strobe.wrEnable ? strobe.enValue : enableQ;
    evBits         = '0;
    evBits[StPer]  = evPeriodic;
    evBits[StAlm]  = evAlarm;
    evBits[StUpd]  = evUpdate;
    freshBits = evBits & ~baseStat & EdgeMask;

    sumNext = baseStat[StSum];
    if (strobe.wrEnable) sumNext = |(enNext & statusQ & FlagMask);
    if (evPeriodic && enNext[StPer]) sumNext = 1'b1;
    if (|(freshBits & enNext)) sumNext = 1'b1;

    statNext        = (baseStat | evBits) & FlagMask;
    statNext[StSum] = sumNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlAQ  <= RstCtrlA;
      enableQ <= RstEnable;
      statusQ <= RstStatus;
    end else begin
      if (strobe.wrCtrlA) ctrlAQ <= strobe.wrValue;
      enableQ <= enNext;
      statusQ <= statNext;
    end
  end
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [DataW-1:0] busWrData,
  output logic [DataW-1:0] busRdData,
  input  logic             evPeriodic,
  input  logic             evAlarm,
  input  logic             evUpdate,
  output logic             irqOut
);
  strobeT           strobe;
  logic [DataW-1:0] ctrlAQ;
  logic [DataW-1:0] enableQ;
  logic [DataW-1:0] statusQ;

  rtc_irq_ctrl uCtrl (
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWrData (busWrData),
    .strobe    (strobe)
  );

  rtc_irq_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evPeriodic (evPeriodic),
    .evAlarm    (evAlarm),
    .evUpdate   (evUpdate),
    .ctrlAQ     (ctrlAQ),
    .enableQ    (enableQ),
    .statusQ    (statusQ)
  );

  always_comb begin
    busRdData = '0;
    if (busRd) begin
      case (busAddr)
        RegCtrlA:  busRdData = ctrlAQ;
        RegEnable: busRdData = enableQ;
        RegStatus: busRdData = statusQ;
        default:   busRdData = RstCtrlD;
      endcase
    end
  end

  assign irqOut = statusQ[StSum];
endmodule

// File: rtl/rtc_irq_checker.sv
module rtc_irq_checker
  import rtc_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [AddrW-1:0] busAddr,
  input logic             busWr,
  input logic             busRd,
  input logic [DataW-1:0] busWrData,
  input logic [DataW-1:0] busRdData,
  input logic             evPeriodic,
  input logic             evAlarm,
  input logic             evUpdate,
  input logic             irqOut,
  input logic [DataW-1:0] enableQ,
  input logic [DataW-1:0] statusQ
);
  p_periodic_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    evPeriodic |=> statusQ[StPer]);

  p_irq_has_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|(statusQ & FlagMask)));

  p_read_drops_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busAddr == RegStatus && !evPeriodic && !evAlarm && !evUpdate)
      |=> (!irqOut && statusQ == 8'h00));

  p_hold_masks_update_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == RegEnable && busWrData[EnHold]) |=> !enableQ[StUpd]);

  p_fixed_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == RegCtrlD) |-> busRdData == RstCtrlD);
endmodule

bind rtc_irq_unit rtc_irq_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRd      (busRd),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .evPeriodic (evPeriodic),
  .evAlarm    (evAlarm),
  .evUpdate   (evUpdate),
  .irqOut     (irqOut),
  .enableQ    (enableQ),
  .statusQ    (statusQ)
);

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busAddr;
  logic       busWr, busRd;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic       evPeriodic, evAlarm, evUpdate;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mA, mEn, mStat;

  always #2.5 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .evPeriodic(evPeriodic),
    .evAlarm(evAlarm), .evUpdate(evUpdate), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mA;
      2'd1: return mEn;
      2'd2: return mStat;
      default: return 8'h80;
    endcase
  endfunction

  // expected state update, written from R2..R9
  task automatic modelStep(input logic [1:0] a, input logic w, input logic r,
                           input logic [7:0] d, input logic p, input logic al, input logic up);
    logic [7:0] base, en, ev, fresh;
    logic sum;
    base = (r && !w && a == 2'd2) ? 8'h00 : mStat;
    en = mEn;
    sum = base[7];
    if (w && a == 2'd1) begin
      en = d[7] ? (d & 8'hEF) : d;
      sum = (en & mStat & 8'h70) != 0;
    end
    if (w && a == 2'd0) mA = d;
    ev = {1'b0, p, al, up, 4'b0};
    fresh = ev & ~base & 8'h30;
    if (p && en[6]) sum = 1'b1;
    if ((fresh & en) != 0) sum = 1'b1;
    mEn = en;
    mStat = {sum, (base[6:4] | ev[6:4]), 4'b0};
  endtask

  // one cycle: drive at negedge, check read, clock, then check irq
  task automatic cyc(input string req, input logic [1:0] a, input logic w, input logic r,
                     input logic [7:0] d, input logic p, input logic al, input logic up);
    busAddr = a; busWr = w; busRd = r; busWrData = d;
    evPeriodic = p; evAlarm = al; evUpdate = up;
    #1;
    check({req, " read"}, busRdData, r ? (w ? expRead(a) : expRead(a)) : 8'h00);
    @(posedge clk);
    modelStep(a, w, r, d, p, al, up);
    @(negedge clk);
    check({req, " irq"}, {7'b0, irqOut}, {7'b0, mStat[7]});
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    cyc(req, a, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic wr(input string req, input logic [1:0] a, input logic [7:0] d);
    cyc(req, a, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7321;
    void'($urandom(seed));
    rstN = 1'b0; busAddr = 0; busWr = 0; busRd = 0; busWrData = 0;
    evPeriodic = 0; evAlarm = 0; evUpdate = 0;
    mA = 8'h26; mEn = 8'h02; mStat = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    check("R1 irq", {7'b0, irqOut}, 8'h00);
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2); rd("R1", 2'd3);
    // R2 periodic without enable: flag only
    cyc("R2", 2'd0, 0, 0, 0, 1, 0, 0);
    check("R2 no irq", {7'b0, irqOut}, 8'h00);
    rd("R2", 2'd2);
    // R2 periodic with enable
    wr("R2", 2'd1, 8'h40);
    cyc("R2", 2'd0, 0, 0, 0, 1, 0, 0);
    check("R2 irq high", {7'b0, irqOut}, 8'h01);
    // R4 read clears
    rd("R4", 2'd2);
    check("R4 irq low", {7'b0, irqOut}, 8'h00);
    rd("R4", 2'd2);
    // R3 alarm with enable, then repeat while set
    wr("R3", 2'd1, 8'h20);
    cyc("R3", 2'd0, 0, 0, 0, 0, 1, 0);
    cyc("R3", 2'd0, 0, 0, 0, 0, 1, 0);
    // R5 write masking pending flag drops line, unmasking raises it at once
    wr("R5", 2'd1, 8'h00);
    check("R5 irq low", {7'b0, irqOut}, 8'h00);
    wr("R5", 2'd1, 8'h20);
    check("R5 irq high", {7'b0, irqOut}, 8'h01);
    rd("R5", 2'd2);
    // R3 update disabled: flag, no line
    cyc("R3", 2'd0, 0, 0, 0, 0, 0, 1);
    check("R3 upd masked", {7'b0, irqOut}, 8'h00);
    rd("R3", 2'd2);
    // R6 hold bit masks update enable
    wr("R6", 2'd1, 8'h90);
    rd("R6", 2'd1);
    cyc("R6", 2'd0, 0, 0, 0, 0, 0, 1);
    check("R6 irq", {7'b0, irqOut}, 8'h00);
    rd("R6", 2'd2);
    wr("R6", 2'd1, 8'h18);
    rd("R6", 2'd1);
    // R7 ignored writes
    wr("R7", 2'd2, 8'hFF);
    wr("R7", 2'd3, 8'h00);
    rd("R7", 2'd2); rd("R7", 2'd3);
    // R8 read and event same cycle
    wr("R8", 2'd1, 8'h20);
    cyc("R8", 2'd2, 0, 1, 0, 0, 1, 0);
    check("R8 irq", {7'b0, irqOut}, 8'h01);
    rd("R8", 2'd2);
    // R9 control byte and write-wins
    wr("R9", 2'd0, 8'h5A);
    rd("R9", 2'd0);
    cyc("R9", 2'd0, 1, 1, 8'hA5, 0, 0, 0);
    rd("R9", 2'd0);
    // random mix (R2..R9)
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic w, r;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 2) == 0);
      cyc("R8 random", a, w, r, 8'($urandom),
          $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule